// File: doc/BRIEF.md
# Shift-Register Periodic Tick Generator

This block produces a single-cycle enable pulse once every `PERIOD` clock cycles. All downstream logic keeps running on the fast system clock and acts only in the cycle the pulse is high. No slower clock is derived. For example, with a 50 MHz clock and a period of 50,000,000 cycles, the pulse arrives once per second.

The cycle count is not held in a binary counter. It is held in a Fibonacci linear feedback shift register. Every cycle the register shifts one place toward its top bit. The new bottom bit is the XOR of a fixed set of tap bits, so no carry travels across the word. The taps come from a maximal-length polynomial, so the register walks through every nonzero state before it repeats.

At elaboration a package function advances the seed `PERIOD-1` times and yields the terminal state. When the register holds that state, the next edge does two things at once: it reloads the seed and it raises the tick for one cycle. The interface is only a clock, a synchronous active-high reset and the tick output.

Top module: `lfsr_tick_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `tick` is 0 after that edge, and the state register holds the seed.
- R2: After reset is released, `tick` is high after rising edges number `PERIOD`, `2*PERIOD`, `3*PERIOD` and so on, counting the first edge with `rst` low as number 1. It is low after every other edge, so with `PERIOD > 1` every pulse lasts exactly one cycle.
- R3: The state register never holds all zeros. A seed parameter whose in-width bits are all zero is replaced by the value 1.
- R4: The edge that finds the register at the terminal state loads the seed into the register and raises `tick` after that same edge.
- R5: With `PERIOD = 1` the terminal state equals the seed, and `tick` stays high after every edge while reset is low.
- R6: The next state is the current state shifted left by one bit. Bit 0 becomes the XOR of the tapped bits. The taps are polynomial terms (26,6,2,1) for width 26, (4,3) for width 4 and (8,6,5,4) for width 8, with term k meaning bit k-1. As a result, `PERIOD = 2^WIDTH - 1` gives a tick every `2^WIDTH - 1` cycles.
- R7: When reset is asserted in the middle of a period, the partial count is discarded. After release, the next tick follows `PERIOD` edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | System clock; all state changes on its rising edge |
| rst  | input  | 1 | Synchronous active-high reset; loads the seed and clears the tick |
| tick | output | 1 | One-cycle enable pulse, once per `PERIOD` cycles |

## Verification
Two events can fall in the same cycle: the terminal-state reload and the tick. When `PERIOD = 1`, the reload and the raised tick land on every single edge. The bench provokes this by sweeping every period from 1 to 15 on a 4-bit register, plus a full 255-cycle period on an 8-bit register. For each instance it judges the tick stream against an arithmetic model, which expects a pulse exactly when the edge count since release is a nonzero multiple of the period. A reset in the middle of a period is also provoked, to show that the partial count is discarded rather than carried into the next tick.

// File: rtl/lfsr_tick_pkg.sv
package lfsr_tick_pkg;

    localparam int MAX_W = 32;

    typedef logic [MAX_W-1:0] word_t;

    // control bundle carried between the comparator and the state register
    typedef struct packed {
        logic hit;   // register currently holds the terminal state
        logic load;  // seed is loaded on the coming edge
    } tick_ctl_t;

    function automatic word_t width_mask(int w);
        if (w >= MAX_W) return '1;
        return (word_t'(1) << w) - word_t'(1);
    endfunction

    // maximal-length feedback taps; polynomial term k maps to bit k-1
    function automatic word_t tap_mask(int w);
        word_t m = '0;
        case (w)
            3:  begin m[2] = 1'b1; m[1] = 1'b1; end
            4:  begin m[3] = 1'b1; m[2] = 1'b1; end
            5:  begin m[4] = 1'b1; m[2] = 1'b1; end
            6:  begin m[5] = 1'b1; m[4] = 1'b1; end
            7:  begin m[6] = 1'b1; m[5] = 1'b1; end
            8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
            16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
            24: begin m[23] = 1'b1; m[22] = 1'b1; m[21] = 1'b1; m[16] = 1'b1; end
            26: begin m[25] = 1'b1; m[5] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
            32: begin m[31] = 1'b1; m[21] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
            default: begin m[w-1] = 1'b1; m[w-2] = 1'b1; end
        endcase
        return m;
    endfunction

    function automatic word_t lfsr_advance(word_t s, word_t taps, int w);
        logic fb;
        fb = ^(s & taps);
        return ((s << 1) | word_t'(fb)) & width_mask(w);
    endfunction

    // state reached after period-1 shifts from the seed
    function automatic word_t lfsr_terminal(word_t seed, word_t taps, int w, int period);
        word_t s = seed;
        for (int i = 1; i < period; i++) s = lfsr_advance(s, taps, w);
        return s;
    endfunction

    function automatic word_t safe_seed(word_t seed, int w);
        if ((seed & width_mask(w)) == '0) return word_t'(1);
        return seed & width_mask(w);
    endfunction

endpackage

// File: rtl/lfsr_tick_step.sv
module lfsr_tick_step
    import lfsr_tick_pkg::*;
#(
    parameter int    WIDTH = 26,
    parameter word_t TAPS  = '0
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    logic [WIDTH-1:0] tapped;

    // each stage takes only its neighbour; bit 0 takes the tap parity
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        if (TAPS[i]) begin : g_on
            assign tapped[i] = cur[i];
        end else begin : g_off
            assign tapped[i] = 1'b0;
        end
    end

    assign nxt[0] = ^tapped;

    for (genvar i = 1; i < WIDTH; i++) begin : g_shift
        assign nxt[i] = cur[i-1];
    end
endmodule

// File: rtl/lfsr_tick_match.sv
module lfsr_tick_match #(
    parameter int               WIDTH = 26,
    parameter int               CHUNK = 4,
    parameter logic [WIDTH-1:0] TERM  = '0
) (
    input  logic [WIDTH-1:0] cur,
    output logic             hit
);
    localparam int NCH = (WIDTH + CHUNK - 1) / CHUNK;

    logic [NCH-1:0] part;

    // compare in slices, then one wide AND
    for (genvar c = 0; c < NCH; c++) begin : g_slice
        localparam int LO = c * CHUNK;
        localparam int HI = ((LO + CHUNK) > WIDTH) ? (WIDTH - 1) : (LO + CHUNK - 1);
        assign part[c] = (cur[HI:LO] == TERM[HI:LO]);
    end

    assign hit = &part;
endmodule

// File: rtl/lfsr_tick_core.sv
module lfsr_tick_core
    import lfsr_tick_pkg::*;
#(
    parameter int               WIDTH  = 26,
    parameter int               PERIOD = 1000,
    parameter logic [WIDTH-1:0] SEED   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] nxt,
    input  tick_ctl_t        ctl,
    output logic [WIDTH-1:0] state,
    output logic             tick
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
            tick  <= 1'b0;
        end else begin
            tick  <= ctl.hit;
            state <= ctl.load ? SEED : nxt;
        end
    end

    // R4: a terminal hit on the last edge leaves the seed in the register
    p_reload_seed_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl.hit)) |-> (state == SEED));

    // R4: a raised tick always coincides with the reloaded seed
    p_tick_at_seed_r4: assert property (@(posedge clk) disable iff (rst)
        tick |-> (state == SEED));

    // R3: never in the lock-up state
    p_never_zero_r3: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    if (PERIOD > 1) begin : g_pulse
        // R2: pulses last one cycle when the period exceeds one
        p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);
    end
endmodule

// File: rtl/lfsr_tick_gen.sv
module lfsr_tick_gen
    import lfsr_tick_pkg::*;
#(
    parameter int    WIDTH  = 26,
    parameter int    PERIOD = 1000,
    parameter word_t SEED   = 1,
    parameter int    CHUNK  = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam word_t TAPS      = tap_mask(WIDTH);
    localparam word_t SEED_FULL = safe_seed(SEED, WIDTH);
    localparam word_t TERM_FULL = lfsr_terminal(SEED_FULL, TAPS, WIDTH, PERIOD);
    localparam logic [WIDTH-1:0] SEED_W = SEED_FULL[WIDTH-1:0];
    localparam logic [WIDTH-1:0] TERM_W = TERM_FULL[WIDTH-1:0];

    logic [WIDTH-1:0] state;
    logic [WIDTH-1:0] nxt;
    logic             hit;
    tick_ctl_t        ctl;

    lfsr_tick_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_step (
        .cur (state),
        .nxt (nxt)
    );

    lfsr_tick_match #(.WIDTH(WIDTH), .CHUNK(CHUNK), .TERM(TERM_W)) u_match (
        .cur (state),
        .hit (hit)
    );

    assign ctl.hit  = hit;
    assign ctl.load = hit;

    lfsr_tick_core #(.WIDTH(WIDTH), .PERIOD(PERIOD), .SEED(SEED_W)) u_core (
        .clk   (clk),
        .rst   (rst),
        .nxt   (nxt),
        .ctl   (ctl),
        .state (state),
        .tick  (tick)
    );
endmodule

// File: tb/sim_lfsr_tick_gen.sv
module sim_lfsr_tick_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    localparam int NW4 = 15;

    logic            tick_main;
    logic            tick_w8;
    logic [NW4:1]    tick_w4;

    lfsr_tick_gen #(.WIDTH(26), .PERIOD(1000), .SEED(1)) u0 (
        .clk(clk), .rst(rst), .tick(tick_main));

    lfsr_tick_gen #(.WIDTH(8), .PERIOD(255), .SEED(8'h5A), .CHUNK(3)) u_w8 (
        .clk(clk), .rst(rst), .tick(tick_w8));

    for (genvar p = 1; p <= NW4; p++) begin : g_w4
        lfsr_tick_gen #(.WIDTH(4), .PERIOD(p), .SEED(p), .CHUNK(2)) u_dut (
            .clk(clk), .rst(rst), .tick(tick_w4[p]));
    end

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;
    bit phase2 = 1'b0;
    bit done = 1'b0;

    // arithmetic model: edges with reset low since the last release
    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    task automatic check(input logic got, input logic exp, input string req, input string who);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s edge=%0d actual=%0b expected=%0b", req, who, edges, got, exp);
        end
    endtask

    function automatic logic model(int period);
        return (edges > 0) && (edges % period == 0);
    endfunction

    task automatic sample_all();
        string tag;
        if (rst) begin
            check(tick_main, 1'b0, "R1", "u0");
            check(tick_w8, 1'b0, "R1", "w8");
            for (int p = 1; p <= NW4; p++) check(tick_w4[p], 1'b0, "R1", "w4");
        end else begin
            tag = phase2 ? "R7" : "R2";
            check(tick_main, model(1000), tag, "u0 p1000");
            // R6: full-length period on the 8-bit taps
            check(tick_w8, model(255), phase2 ? "R7" : "R6", "w8 p255");
            for (int p = 1; p <= NW4; p++) begin
                if (p == 1)            check(tick_w4[p], model(p), "R5", "w4 p1");
                else if (p == NW4)     check(tick_w4[p], model(p), "R6", "w4 p15");
                else if (edges > 2*p)  check(tick_w4[p], model(p), "R4", "w4 reload");
                else                   check(tick_w4[p], model(p), tag, "w4");
            end
            // R3: sequences keep repeating long after many periods, so no lock-up
            if (edges == 2000) check(tick_main, 1'b1, "R3", "u0 second period");
        end
    endtask

    initial begin
        repeat (4) begin
            @(negedge clk);
            sample_all();   // R1 during reset
        end
        rst = 1'b0;
        repeat (2100) begin
            @(negedge clk);
            sample_all();
        end
        // R7: reset in the middle of a period
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            sample_all();
        end
        phase2 = 1'b1;
        rst = 1'b0;
        repeat (1100) begin
            @(negedge clk);
            sample_all();
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule